// File: doc/BRIEF.md
# SPI-Priority I2C Access Arbiter

This block sits between the SPI command port and the I2C engine of a bridge whose I2C side can act both as a bus master and as an addressed slave. A command arriving on SPI always wins over I2C activity. The block watches the SPI chip select and the command framing pulses from the command decoder. It also watches the I2C bus-busy flag and whether the engine is currently driving a transfer as master. From these it produces three controls for the I2C engine: an enable that permits acknowledging this device's own slave address, a stall request for an in-flight master transfer, and a one-cycle resume pulse.

The choice is made on the first system-clock cycle after the synchronized chip select falls.
- **Engine is master:** the block requests a stall. The engine parks at its next bit boundary with SCL held low, so the bus stays owned. The stall is held until the decoder reports the command fully processed, not merely shifted in. After that the engine is told to continue where it stopped.
- **Bus is idle:** slave address acknowledgement is withdrawn at once for the whole command.
- **Bus is busy with another master's traffic:** an acknowledge already in progress is left alone, and masking starts at the next START condition.

A frame in which chip select rises before any command started is treated as empty, and the block returns to idle.

Top module: `spi_i2c_arbiter`

## Requirements
- R1: After a synchronous reset, `i2c_slave_ack_en` is 1, `i2c_stall_req` is 0 and `i2c_resume` is 0.
- R2: A frame that begins while `i2c_bus_busy` is 0 drives `i2c_slave_ack_en` to 0 until the command ends. A command ends on the rising edge of the synchronized `spi_cmd_done`.
- R3: `i2c_addr_ack` equals `i2c_addr_match` AND `i2c_slave_ack_en`. An address match while masked is therefore NACKed (0).
- R4: A frame that begins while `i2c_master_active` is 1 sets `i2c_stall_req` to 1 and `i2c_slave_ack_en` to 0. Master activity takes priority over the busy flag.
- R5: Once a command has started (`spi_cmd_start` seen), the stall request and the masking persist after chip select rises, until `spi_cmd_done` rises.
- R6: When a stalled command ends, `i2c_stall_req` returns to 0. `i2c_resume` pulses high for exactly one cycle if `i2c_stall_ack` was seen during the stall, and stays 0 otherwise.
- R7: A frame that begins while the bus is busy and the engine is not master leaves `i2c_slave_ack_en` at 1 until an `i2c_start_seen` pulse; from then it is 0 until the command ends.
- R8: If chip select rises with no `spi_cmd_start` in the frame, the block returns to idle: ack enabled and no stall.
- R9: Consecutive frames are each classified afresh from the bus state at their own start. A frame starting in the resume cycle is honoured.
- R10: `spi_cs_n` and `spi_cmd_done` pass through two synchronizer flops, so the outputs do not react within two clock edges of a chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | SPI chip select, active low, asynchronous |
| spi_cmd_start | input | 1 | Decoder pulse: a command byte was received |
| spi_cmd_done | input | 1 | Decoder level: command fully processed, asynchronous |
| i2c_bus_busy | input | 1 | I2C bus is between START and STOP |
| i2c_master_active | input | 1 | Engine is driving a transfer as master |
| i2c_start_seen | input | 1 | One-cycle pulse on a START condition |
| i2c_addr_match | input | 1 | Address phase matches own slave address |
| i2c_stall_ack | input | 1 | Engine has parked at a bit boundary |
| i2c_slave_ack_en | output | 1 | Permission to ACK own address |
| i2c_addr_ack | output | 1 | ACK decision for the current address phase |
| i2c_stall_req | output | 1 | Request to suspend the master transfer |
| i2c_resume | output | 1 | One-cycle pulse to continue the master transfer |

## Verification
The bench targets five corner cases, each tied to a specific failure.
- **Command done after chip select rises.** A design that releases on chip select would resume the master transfer during a register readback.
- **Busy bus with another master.** A design that masks at frame start would cut off an acknowledge already owed.
- **Empty frame.** A design that waits for command-done would hang masked forever.
- **Resume without stall acknowledge.** A design that always pulses resume would restart an engine that never parked.
- **Synchronizer latency.** Early output movement would expose an unsynchronized chip select.

Random mixes of bus state and framing, run back to back, check that each frame is classified from its own start conditions.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASK   = 2'd1,
        ST_STALL  = 2'd2,
        ST_RESUME = 2'd3
    } arb_state_t;

    typedef struct packed {
        logic ack_en;
        logic stall_req;
        logic resume;
    } arb_ctl_t;

    localparam arb_ctl_t CTL_IDLE = '{ack_en: 1'b1, stall_req: 1'b0, resume: 1'b0};

    // pick the frame class from the bus status at frame start
    function automatic arb_state_t frame_class(input logic master_act);
        return master_act ? ST_STALL : ST_MASK;
    endfunction

    // a frame with no command byte ends when chip select rises
    function automatic logic frame_over(input logic done_rise, input logic cs_rise,
                                        input logic started, input logic start_now);
        return done_rise || (cs_rise && !started && !start_now);
    endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/arb_edge.sv
module arb_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    assign rise = lvl && !prev;
    assign fall = !lvl && prev;
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_fall,
    input  logic     cs_rise,
    input  logic     done_rise,
    input  logic     cmd_start,
    input  logic     bus_busy,
    input  logic     master_act,
    input  logic     start_det,
    input  logic     stall_ack,
    output arb_ctl_t ctl
);
    arb_state_t state;
    logic       started;
    logic       acked;
    logic       ending;

    assign ending = frame_over(done_rise, cs_rise, started, cmd_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctl     <= CTL_IDLE;
            started <= 1'b0;
            acked   <= 1'b0;
        end else begin
            ctl.resume <= 1'b0;
            case (state)
                ST_IDLE, ST_RESUME: begin
                    state <= ST_IDLE;
                    if (cs_fall) begin
                        started <= 1'b0;
                        acked   <= 1'b0;
                        state   <= frame_class(master_act);
                        if (master_act) begin
                            ctl.stall_req <= 1'b1;
                            ctl.ack_en    <= 1'b0;
                        end else begin
                            ctl.ack_en    <= bus_busy;
                        end
                    end
                end
                ST_MASK: begin
                    if (cmd_start) started <= 1'b1;
                    if (start_det) ctl.ack_en <= 1'b0;
                    if (ending) begin
                        state      <= ST_IDLE;
                        ctl.ack_en <= 1'b1;
                    end
                end
                ST_STALL: begin
                    if (cmd_start) started <= 1'b1;
                    if (stall_ack) acked <= 1'b1;
                    if (ending) begin
                        ctl.stall_req <= 1'b0;
                        ctl.ack_en    <= 1'b1;
                        if (acked || stall_ack) begin
                            state      <= ST_RESUME;
                            ctl.resume <= 1'b1;
                        end else begin
                            state      <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_stall_masks_ack_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.stall_req |-> !ctl.ack_en);

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.stall_req && !done_rise && !cs_rise) |=> ctl.stall_req);

    assert_resume_single_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.resume |=> !ctl.resume);

    assert_resume_after_stall_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.resume |-> $past(ctl.stall_req));

    assert_ack_fall_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.ack_en) |-> $past(cs_fall || start_det));

endmodule

// File: rtl/spi_i2c_arbiter.sv
module spi_i2c_arbiter
    import arb_pkg::*;
#(
    parameter int SYNC_DEPTH = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_cmd_start,
    input  logic spi_cmd_done,
    input  logic i2c_bus_busy,
    input  logic i2c_master_active,
    input  logic i2c_start_seen,
    input  logic i2c_addr_match,
    input  logic i2c_stall_ack,
    output logic i2c_slave_ack_en,
    output logic i2c_addr_ack,
    output logic i2c_stall_req,
    output logic i2c_resume
);
    logic     cs_n_s, done_s;
    logic     cs_rise_n, cs_fall_n;
    logic     done_rise, done_fall_unused;
    arb_ctl_t ctl;

    arb_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) i_sync_cs (
        .clk(clk), .rst(rst), .d(spi_cs_n), .q(cs_n_s));

    arb_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) i_sync_done (
        .clk(clk), .rst(rst), .d(spi_cmd_done), .q(done_s));

    arb_edge #(.RST_VAL(1'b1)) i_edge_cs (
        .clk(clk), .rst(rst), .lvl(cs_n_s), .rise(cs_rise_n), .fall(cs_fall_n));

    arb_edge #(.RST_VAL(1'b0)) i_edge_done (
        .clk(clk), .rst(rst), .lvl(done_s), .rise(done_rise), .fall(done_fall_unused));

    arb_fsm i_fsm (
        .clk(clk), .rst(rst),
        .cs_fall(cs_fall_n), .cs_rise(cs_rise_n), .done_rise(done_rise),
        .cmd_start(spi_cmd_start),
        .bus_busy(i2c_bus_busy), .master_act(i2c_master_active),
        .start_det(i2c_start_seen), .stall_ack(i2c_stall_ack),
        .ctl(ctl));

    assign i2c_slave_ack_en = ctl.ack_en;
    assign i2c_stall_req    = ctl.stall_req;
    assign i2c_resume       = ctl.resume;
    assign i2c_addr_ack     = i2c_addr_match && ctl.ack_en;

    assert_quiet_after_cs_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(i2c_slave_ack_en) && !i2c_stall_req) |-> ($past(i2c_start_seen) || !cs_n_s));

endmodule

// File: tb/test_spi_i2c_arbiter.sv
module test_spi_i2c_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_cs_n = 1'b1, spi_cmd_start = 1'b0, spi_cmd_done = 1'b0;
    logic i2c_bus_busy = 1'b0, i2c_master_active = 1'b0, i2c_start_seen = 1'b0;
    logic i2c_addr_match = 1'b0, i2c_stall_ack = 1'b0;
    logic i2c_slave_ack_en, i2c_addr_ack, i2c_stall_req, i2c_resume;

    int total = 0;
    int bad = 0;
    int resume_cnt = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;

    spi_i2c_arbiter i_spi_i2c_arbiter (
        .clk(clk), .rst(rst),
        .spi_cs_n(spi_cs_n), .spi_cmd_start(spi_cmd_start), .spi_cmd_done(spi_cmd_done),
        .i2c_bus_busy(i2c_bus_busy), .i2c_master_active(i2c_master_active),
        .i2c_start_seen(i2c_start_seen), .i2c_addr_match(i2c_addr_match),
        .i2c_stall_ack(i2c_stall_ack),
        .i2c_slave_ack_en(i2c_slave_ack_en), .i2c_addr_ack(i2c_addr_ack),
        .i2c_stall_req(i2c_stall_req), .i2c_resume(i2c_resume));

    always @(negedge clk) if (!rst && i2c_resume) resume_cnt++;

    // mode: 0 bus idle, 1 busy with other master, 2 engine is master
    function automatic int exp_ack_at_start(input int mode);
        return (mode == 1) ? 1 : 0;
    endfunction
    function automatic int exp_stall(input int mode);
        return (mode == 2) ? 1 : 0;
    endfunction
    function automatic int exp_resumes(input int mode, input bit ack);
        return (mode == 2 && ack) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input int mode, input bit empty, input bit give_ack, input bit chk_sync);
        int r0;
        i2c_bus_busy      = (mode != 0);
        i2c_master_active = (mode == 2);
        r0 = resume_cnt;
        spi_cs_n = 1'b0;
        if (chk_sync) begin
            cyc(2);
            chk("R10 no reaction before sync", i2c_slave_ack_en, 1);
            cyc(2);
        end else begin
            cyc(4);
        end
        chk((mode == 1) ? "R7 ack kept on busy bus" : "R2 ack masked", i2c_slave_ack_en, exp_ack_at_start(mode));
        chk("R4 stall request", i2c_stall_req, exp_stall(mode));
        i2c_addr_match = 1'b1;
        #1;
        chk("R3 address ack decision", i2c_addr_ack, exp_ack_at_start(mode));
        i2c_addr_match = 1'b0;
        if (mode == 1) begin
            i2c_start_seen = 1'b1;
            cyc(1);
            i2c_start_seen = 1'b0;
            chk("R7 masked after START", i2c_slave_ack_en, 0);
        end
        if (give_ack && mode == 2) begin
            i2c_stall_ack = 1'b1;
            cyc(1);
            i2c_stall_ack = 1'b0;
        end
        if (!empty) begin
            spi_cmd_start = 1'b1;
            cyc(1);
            spi_cmd_start = 1'b0;
        end
        spi_cs_n = 1'b1;
        cyc(4);
        if (!empty) begin
            chk("R5 stall held past cs rise", i2c_stall_req, exp_stall(mode));
            chk("R5 mask held past cs rise", i2c_slave_ack_en, 0);
            spi_cmd_done = 1'b1;
            cyc(3);
            spi_cmd_done = 1'b0;
            cyc(2);
        end else begin
            cyc(1);
        end
        chk(empty ? "R8 ack restored" : "R6 ack restored", i2c_slave_ack_en, 1);
        chk(empty ? "R8 stall released" : "R6 stall released", i2c_stall_req, 0);
        chk("R6 resume pulses", resume_cnt - r0, exp_resumes(mode, give_ack));
    endtask

    task automatic run_all();
        void'($urandom(32'd20240611));
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 reset ack_en", i2c_slave_ack_en, 1);
        chk("R1 reset stall", i2c_stall_req, 0);
        chk("R1 reset resume", i2c_resume, 0);
        run_frame(0, 1'b0, 1'b0, 1'b1);
        run_frame(2, 1'b0, 1'b1, 1'b0);
        run_frame(2, 1'b0, 1'b0, 1'b0);
        run_frame(1, 1'b0, 1'b0, 1'b1);
        run_frame(0, 1'b1, 1'b0, 1'b0);
        run_frame(2, 1'b1, 1'b1, 1'b0);
        // R9 back to back with changing bus state
        run_frame(2, 1'b0, 1'b1, 1'b0);
        run_frame(0, 1'b0, 1'b0, 1'b0);
        run_frame(1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 30; k++) begin
            run_frame(int'($urandom % 3), ($urandom % 4) == 0, $urandom % 2, 1'b0);
            cyc(int'($urandom % 3));
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule